// File: doc/BRIEF.md
# Prescaled PWM Timer Channel

This block produces one pulse-width-modulated output from an up-counter whose width is set by a parameter (24 bits by default). A dedicated counter clock drives the counter through a prescaler that divides by 1, 16, 256 or 2048. In each period the output is at its active level from the count of zero until the count reaches the duty value, and at its inactive level for the rest. A polarity bit chooses which level is the active one. Three events are caught as sticky status flags: a rising edge on the output, a falling edge on the output, and the counter wrapping back to zero. A single interrupt line reports any flag whose enable bit is set.

Software programs the channel through a small register port on a bus clock. The bus clock has no fixed relationship to the counter clock, and either clock may be the faster one. Each configuration write travels to the counter domain through a toggle handshake. A busy bit shows when that transfer is still in flight. A new period or duty value written while the channel runs is held back until the counter next clears, so a period never ends early or runs long.

Top module: `pwm_timer_chan`

## Requirements
- R1: With period register P, the counter runs 0,1,...,P and then clears to 0 on the next prescaled tick, so one output period lasts (P+1)*div counter-clock cycles.
- R2: CTRL bits [3:2] select the prescale divisor: 0 gives /1, 1 gives /16, 2 gives /256, 3 gives /2048. Between ticks the counter holds its value.
- R3: With a duty value D where 0 < D < P, the output is at its active level for D*div cycles at the start of each period. D = 0 gives a constant inactive level. D >= P gives a constant active level.
- R4: CTRL bit 1 sets the polarity. When it is 0, the active level is high. When it is 1, the active level is low and the output is inverted.
- R5: When CTRL bit 0 (enable) is 0, the counter holds at 0 and the output sits at its inactive level, which equals CTRL bit 1. Period and duty values written while the channel is disabled are in force from the moment it is enabled.
- R6: A period or duty value written while the channel runs takes effect only at the next counter clear. The period in progress completes with its old length.
- R7: CTRL reads back a busy flag in bit 8. The flag is set from a configuration write until that write has reached the counter domain. Writes to CTRL (address 0), PERIOD (address 1) or DUTY (address 2) while the flag is set are ignored.
- R8: STATUS (address 3) holds sticky flags: bit 0 for an output rising edge, bit 1 for an output falling edge and bit 2 for a counter clear. Writing 1 to a bit clears that bit, and writing 0 leaves it unchanged.
- R9: irq is high exactly when some STATUS flag is set and its enable is set. The enables are CTRL bit 4 for rise, bit 5 for fall and bit 6 for clear.
- R10: Behaviour is the same whether the counter clock is faster or slower than the bus clock.
- R11: After reset, all registers read 0 and both pwm_out and irq are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_bus | input | 1 | Register-port clock |
| rst_bus | input | 1 | Synchronous active-high reset, bus domain |
| clk_cnt | input | 1 | Counter clock |
| rst_cnt | input | 1 | Synchronous active-high reset, counter domain |
| wr_en | input | 1 | Write strobe for the register at reg_addr |
| reg_addr | input | 2 | Register select: 0 CTRL, 1 PERIOD, 2 DUTY, 3 STATUS |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for the register at reg_addr (combinational) |
| irq | output | 1 | Combined interrupt request |
| pwm_out | output | 1 | PWM output, registered in the counter domain |

## Verification
The bench builds the channel with a 10-bit counter and two-stage synchronizers. With this width, an all-ones period of 1023 and a duty just below it can be run at /1 in about a thousand cycles. The /256 and /2048 divisors are run with periods of a few counts, so every prescaler setting is measured in full. The counter clock runs first at 7 ns against the 20 ns bus clock and then at 47 ns, so the handshakes are exercised with each domain in turn being the faster one.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

    localparam int PRE_W    = 11;
    localparam int BUSY_BIT = 8;

    typedef enum logic [1:0] {
        REG_CTRL   = 2'd0,
        REG_PERIOD = 2'd1,
        REG_DUTY   = 2'd2,
        REG_STATUS = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        DIV_1    = 2'd0,
        DIV_16   = 2'd1,
        DIV_256  = 2'd2,
        DIV_2048 = 2'd3
    } div_sel_e;

    // bit 2 wrap, bit 1 fall, bit 0 rise
    typedef struct packed {
        logic wrap;
        logic fall;
        logic rise;
    } evt_t;

    // [6:4] enables, [3:2] divisor, [1] polarity, [0] run
    typedef struct packed {
        evt_t     ien;
        div_sel_e psel;
        logic     inv;
        logic     en;
    } ctrl_t;

    function automatic logic [PRE_W-1:0] pre_mask(div_sel_e s);
        case (s)
            DIV_1:    return PRE_W'(0);
            DIV_16:   return PRE_W'(15);
            DIV_256:  return PRE_W'(255);
            default:  return PRE_W'(2047);
        endcase
    endfunction

endpackage

// File: rtl/pwm_sync.sv
module pwm_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W       = 24,
    parameter int SYNC_STAGES = 2,
    parameter int DATA_W      = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    input  logic              ack_tog,
    input  logic [2:0]        evt_tog,
    output logic              req_tog,
    output ctrl_t             ctrl_q,
    output logic [CNT_W-1:0]  period_q,
    output logic [CNT_W-1:0]  duty_q,
    output logic              busy,
    output logic [2:0]        flags
);
    localparam int CTRL_W = $bits(ctrl_t);

    logic       ack_s;
    logic [2:0] evt_s, evt_d, set_v, clr_v;
    logic       cfg_wr;
    reg_sel_e   sel;

    pwm_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(clk), .rst(rst), .d(ack_tog), .q(ack_s)
    );
    pwm_sync #(.W(3), .STAGES(SYNC_STAGES)) u_evt_sync (
        .clk(clk), .rst(rst), .d(evt_tog), .q(evt_s)
    );

    assign sel    = reg_sel_e'(addr);
    assign busy   = req_tog ^ ack_s;
    assign cfg_wr = wr_en && !busy && (sel != REG_STATUS);
    assign clr_v  = (wr_en && sel == REG_STATUS) ? wdata[2:0] : 3'b000;
    assign set_v  = evt_s ^ evt_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_tog  <= 1'b0;
            ctrl_q   <= '0;
            period_q <= '0;
            duty_q   <= '0;
            evt_d    <= '0;
            flags    <= '0;
        end else begin
            evt_d <= evt_s;
            flags <= (flags & ~clr_v) | set_v;
            if (cfg_wr) begin
                req_tog <= ~req_tog;
                case (sel)
                    REG_CTRL:   ctrl_q   <= ctrl_t'(wdata[CTRL_W-1:0]);
                    REG_PERIOD: period_q <= wdata[CNT_W-1:0];
                    REG_DUTY:   duty_q   <= wdata[CNT_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (sel)
            REG_CTRL: begin
                rdata[CTRL_W-1:0] = ctrl_q;
                rdata[BUSY_BIT]   = busy;
            end
            REG_PERIOD: rdata[CNT_W-1:0] = period_q;
            REG_DUTY:   rdata[CNT_W-1:0] = duty_q;
            default:    rdata[2:0]       = flags;
        endcase
    end

    assign irq = |(flags & ctrl_q.ien);
endmodule

// File: rtl/pwm_core.sv
module pwm_core
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W       = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_tog,
    input  ctrl_t            ctrl_in,
    input  logic [CNT_W-1:0] period_in,
    input  logic [CNT_W-1:0] duty_in,
    output logic             ack_tog,
    output logic [2:0]       evt_tog,
    output logic             pwm_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] per_o,
    output logic             tick_o,
    output logic             en_o,
    output logic             inv_o
);
    logic             req_s, req_d, take;
    logic             en_c, inv_c, pend_v;
    div_sel_e         psel_c;
    logic [CNT_W-1:0] pend_per, pend_duty, act_per, act_duty, cnt;
    logic [PRE_W-1:0] pre, mask;
    logic             tick, hit, wrap, load_run, active, pwm_q, pwm_d;

    pwm_sync #(.W(1), .STAGES(SYNC_STAGES)) u_req_sync (
        .clk(clk), .rst(rst), .d(req_tog), .q(req_s)
    );

    assign take     = req_s ^ req_d;
    assign mask     = pre_mask(psel_c);
    assign tick     = en_c && ((pre & mask) == mask);
    assign hit      = cnt >= act_per;
    assign wrap     = tick && hit;
    assign load_run = wrap && pend_v;
    assign active   = (act_duty != '0) && ((cnt < act_duty) || (act_duty >= act_per));

    always_ff @(posedge clk) begin
        if (rst) begin
            req_d     <= 1'b0;
            en_c      <= 1'b0;
            inv_c     <= 1'b0;
            psel_c    <= DIV_1;
            pend_per  <= '0;
            pend_duty <= '0;
            pend_v    <= 1'b0;
            act_per   <= '0;
            act_duty  <= '0;
            cnt       <= '0;
            pre       <= '0;
            pwm_q     <= 1'b0;
            pwm_d     <= 1'b0;
            evt_tog   <= '0;
        end else begin
            req_d <= req_s;
            if (take) begin
                en_c      <= ctrl_in.en;
                inv_c     <= ctrl_in.inv;
                psel_c    <= ctrl_in.psel;
                pend_per  <= period_in;
                pend_duty <= duty_in;
            end
            if (!en_c) begin
                cnt    <= '0;
                pre    <= '0;
                pend_v <= 1'b0;
                if (take) begin
                    act_per  <= period_in;
                    act_duty <= duty_in;
                end else if (pend_v) begin
                    act_per  <= pend_per;
                    act_duty <= pend_duty;
                end
            end else begin
                pre <= pre + 1'b1;
                if (tick) cnt <= hit ? '0 : cnt + 1'b1;
                if (load_run) begin
                    act_per  <= pend_per;
                    act_duty <= pend_duty;
                end
                if (take)          pend_v <= 1'b1;
                else if (load_run) pend_v <= 1'b0;
            end
            pwm_q   <= en_c ? (active ^ inv_c) : inv_c;
            pwm_d   <= pwm_q;
            evt_tog <= evt_tog ^ {wrap, pwm_d & ~pwm_q, pwm_q & ~pwm_d};
        end
    end

    assign ack_tog = req_d;
    assign pwm_o   = pwm_q;
    assign cnt_o   = cnt;
    assign per_o   = act_per;
    assign tick_o  = tick;
    assign en_o    = en_c;
    assign inv_o   = inv_c;
endmodule

// File: rtl/pwm_timer_chan.sv
module pwm_timer_chan
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W       = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk_bus,
    input  logic        rst_bus,
    input  logic        clk_cnt,
    input  logic        rst_cnt,
    input  logic        wr_en,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        irq,
    output logic        pwm_out
);
    logic             req_w, ack_w, busy_w, tick_w, en_w, inv_w;
    logic [2:0]       evt_w, flags_w;
    ctrl_t            ctrl_w;
    logic [CNT_W-1:0] period_w, duty_w, cnt_w, per_w;

    pwm_regs #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES), .DATA_W(32)) u_regs (
        .clk(clk_bus), .rst(rst_bus), .wr_en(wr_en), .addr(reg_addr),
        .wdata(wr_data), .rdata(rd_data), .irq(irq),
        .ack_tog(ack_w), .evt_tog(evt_w), .req_tog(req_w),
        .ctrl_q(ctrl_w), .period_q(period_w), .duty_q(duty_w),
        .busy(busy_w), .flags(flags_w)
    );

    pwm_core #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_core (
        .clk(clk_cnt), .rst(rst_cnt), .req_tog(req_w), .ctrl_in(ctrl_w),
        .period_in(period_w), .duty_in(duty_w), .ack_tog(ack_w),
        .evt_tog(evt_w), .pwm_o(pwm_out), .cnt_o(cnt_w), .per_o(per_w),
        .tick_o(tick_w), .en_o(en_w), .inv_o(inv_w)
    );
endmodule

// File: rtl/pwm_timer_chan_chk.sv
module pwm_timer_chan_chk #(
    parameter int CNT_W = 24
) (
    input logic             clk_bus,
    input logic             rst_bus,
    input logic             clk_cnt,
    input logic             rst_cnt,
    input logic             wr_en,
    input logic [1:0]       reg_addr,
    input logic [31:0]      wr_data,
    input logic             pwm_out,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] per,
    input logic             tick,
    input logic             en,
    input logic             inv,
    input logic             busy,
    input logic [CNT_W-1:0] period_q,
    input logic [2:0]       flags
);
    // R1
    cnt_range_chk: assert property (@(posedge clk_cnt) disable iff (rst_cnt)
        cnt <= per);

    // R1
    wrap_zero_chk: assert property (@(posedge clk_cnt) disable iff (rst_cnt)
        (en && tick && cnt >= per) |=> (cnt == '0));

    // R2
    hold_between_ticks_chk: assert property (@(posedge clk_cnt) disable iff (rst_cnt)
        (en && !tick) |=> $stable(cnt));

    // R5
    disabled_level_chk: assert property (@(posedge clk_cnt) disable iff (rst_cnt)
        !en |=> (pwm_out == $past(inv)));

    // R7
    busy_write_ignored_chk: assert property (@(posedge clk_bus) disable iff (rst_bus)
        (wr_en && busy && reg_addr == 2'd1) |=> $stable(period_q));

    // R8
    wrap_flag_sticky_chk: assert property (@(posedge clk_bus) disable iff (rst_bus)
        (flags[2] && !(wr_en && reg_addr == 2'd3 && wr_data[2])) |=> flags[2]);
endmodule

bind pwm_timer_chan pwm_timer_chan_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_bus(clk_bus), .rst_bus(rst_bus), .clk_cnt(clk_cnt), .rst_cnt(rst_cnt),
    .wr_en(wr_en), .reg_addr(reg_addr), .wr_data(wr_data), .pwm_out(pwm_out),
    .cnt(cnt_w), .per(per_w), .tick(tick_w), .en(en_w), .inv(inv_w),
    .busy(busy_w), .period_q(period_w), .flags(flags_w)
);

// File: tb/pwm_timer_chan_tb.sv
`timescale 1ns/1ps
module pwm_timer_chan_tb;
    localparam int CW = 10;

    logic        clk_bus = 1'b0, clk_cnt = 1'b0;
    logic        rst_bus = 1'b1, rst_cnt = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq, pwm_out;

    realtime cnt_half = 3.5;
    int total = 0, fails = 0, bus_cyc = 0;
    int cyc_c = 0, rise_at = 0, last_per = 0, last_act = 0, rises = 0;
    logic pol = 1'b0, a_prev = 1'b0;

    pwm_timer_chan #(.CNT_W(CW), .SYNC_STAGES(2)) u_dut (
        .clk_bus(clk_bus), .rst_bus(rst_bus), .clk_cnt(clk_cnt), .rst_cnt(rst_cnt),
        .wr_en(wr_en), .reg_addr(reg_addr), .wr_data(wr_data), .rd_data(rd_data),
        .irq(irq), .pwm_out(pwm_out)
    );

    always #10 clk_bus = ~clk_bus;
    always #(cnt_half) clk_cnt = ~clk_cnt;

    // waveform monitor in the counter domain, in terms of the active level
    always @(negedge clk_cnt) begin
        logic a;
        cyc_c++;
        a = pwm_out ^ pol;
        if (a && !a_prev) begin
            last_per = cyc_c - rise_at;
            rise_at  = cyc_c;
            rises++;
        end
        if (!a && a_prev) last_act = cyc_c - rise_at;
        a_prev = a;
    end

    always @(posedge clk_bus) begin
        bus_cyc++;
        if (bus_cyc > 190000) begin
            fails++; total++;
            $display("FAIL watchdog: got %0d bus cycles expected fewer", bus_cyc);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    function automatic int divv(int sel);
        case (sel)
            0: return 1;
            1: return 16;
            2: return 256;
            default: return 2048;
        endcase
    endfunction

    function automatic int ctrl_word(int ien, int psel, int inv, int en);
        return (ien << 4) | (psel << 2) | (inv << 1) | en;
    endfunction

    task automatic check(input string req, input longint got, input longint exp);
        total++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic bwrite(input int a, input int d);
        @(negedge clk_bus);
        wr_en = 1'b1; reg_addr = 2'(a); wr_data = 32'(d);
        @(negedge clk_bus);
        wr_en = 1'b0;
    endtask

    task automatic bread(input int a, output int d);
        @(negedge clk_bus);
        reg_addr = 2'(a);
        #1 d = int'(rd_data);
    endtask

    task automatic wait_idle();
        int v;
        do bread(0, v); while (v[8]);
    endtask

    task automatic const_chk(input string req, input logic level, input int n);
        int bad = 0;
        repeat (n) begin
            @(negedge clk_cnt);
            if (pwm_out !== level) bad++;
        end
        check(req, bad, 0);
    endtask

    task automatic setup(input int psel, input int inv, input int p, input int d, input int ien);
        bwrite(0, ctrl_word(ien, psel, inv, 0)); wait_idle();
        bwrite(1, p); wait_idle();
        bwrite(2, d); wait_idle();
        pol = inv[0];
        bwrite(0, ctrl_word(ien, psel, inv, 1)); wait_idle();
    endtask

    task automatic run_case(input string req, input int psel, input int inv, input int p, input int d);
        int dv, n0;
        dv = divv(psel);
        setup(psel, inv, p, d, 0);
        if (d == 0) begin
            repeat (4) @(negedge clk_cnt);
            const_chk({req, " zero duty"}, inv[0], 3 * (p + 1) * dv);
        end else if (d >= p) begin
            repeat (4) @(negedge clk_cnt);
            const_chk({req, " full duty"}, ~inv[0], 3 * (p + 1) * dv);
        end else begin
            n0 = rises;
            wait (rises >= n0 + 2);
            check({req, " period"}, last_per, (p + 1) * dv);
            check({req, " active"}, last_act, d * dv);
        end
    endtask

    initial begin
        int v, n0, n1, psel, p, d, inv;
        v = int'($urandom(32'd20240611));
        repeat (6) @(negedge clk_bus);
        rst_bus = 1'b0; rst_cnt = 1'b0;
        repeat (2) @(negedge clk_bus);

        // R11 reset state
        for (int a = 0; a < 4; a++) begin
            bread(a, v);
            check("R11 reg reset", v, 0);
        end
        check("R11 pwm_out reset", pwm_out, 0);
        check("R11 irq reset", irq, 0);

        // R5 disabled output level follows polarity
        pol = 1'b1;
        bwrite(0, ctrl_word(0, 0, 1, 0)); wait_idle();
        const_chk("R5 disabled inv=1", 1'b1, 40);
        pol = 1'b0;
        bwrite(0, ctrl_word(0, 0, 0, 0)); wait_idle();
        const_chk("R5 disabled inv=0", 1'b0, 40);

        // R1 R2 R3 R4 directed
        run_case("R1/R3 div1", 0, 0, 9, 4);
        run_case("R4 inverted", 0, 1, 9, 3);
        run_case("R2 div16", 1, 0, 5, 2);
        run_case("R2 div256", 2, 1, 3, 1);
        run_case("R2 div2048", 3, 0, 2, 1);
        run_case("R3 duty zero", 0, 0, 7, 0);
        run_case("R3 duty equals period", 0, 1, 7, 7);
        run_case("R3 duty above period", 0, 0, 7, 12);
        run_case("R1 full-scale period", 0, 0, 1023, 1022);
        run_case("R3 full-scale full duty", 0, 1, 1023, 1023);

        // R1 R2 R3 R4 random, counter clock faster than bus clock
        for (int i = 0; i < 10; i++) begin
            psel = int'($urandom % 2);
            p    = 2 + int'($urandom % 24);
            d    = int'($urandom % (p + 3));
            inv  = int'($urandom % 2);
            run_case("R1/R2/R3/R4 random", psel, inv, p, d);
        end

        // R6 period change while running is deferred to the next clear
        setup(0, 0, 60, 5, 0);
        n0 = rises;
        wait (rises >= n0 + 1);
        repeat (30) @(negedge clk_cnt);
        bwrite(1, 10);
        n1 = rises;
        wait (rises >= n1 + 1);
        check("R6 period in progress keeps old length", last_per, 61);
        wait (rises >= n1 + 2);
        check("R6 new period after clear", last_per, 11);

        // R7 write while busy is dropped
        wait_idle();
        @(negedge clk_bus);
        wr_en = 1'b1; reg_addr = 2'd0; wr_data = 32'(ctrl_word(0, 0, 0, 1));
        @(negedge clk_bus);
        reg_addr = 2'd1; wr_data = 32'd77;
        @(negedge clk_bus);
        wr_en = 1'b0; reg_addr = 2'd0;
        #1 check("R7 busy after write", rd_data[8], 1);
        wait_idle();
        bread(1, v);
        check("R7 period write while busy ignored", v, 10);

        // R8 R9 flags and interrupt
        setup(0, 0, 20, 7, 0);
        repeat (60) @(negedge clk_bus);
        bread(3, v);
        check("R8 all flags set", v, 7);
        check("R9 irq low with enables clear", irq, 0);
        bwrite(0, ctrl_word(4, 0, 0, 1)); wait_idle();
        repeat (2) @(negedge clk_bus);
        check("R9 irq high with clear enable", irq, 1);
        bwrite(0, ctrl_word(4, 0, 0, 0)); wait_idle();
        repeat (20) @(negedge clk_bus);
        bwrite(3, 1);
        bread(3, v);
        check("R8 write-one clears only rise", v, 6);
        check("R9 irq stays with clear flag", irq, 1);
        bwrite(3, 6);
        bread(3, v);
        check("R8 remaining flags cleared", v, 0);
        check("R9 irq low after clear", irq, 0);

        // R10 counter clock slower than bus clock
        cnt_half = 23.5;
        repeat (10) @(negedge clk_cnt);
        run_case("R10 slow div1", 0, 0, 9, 4);
        run_case("R10 slow div16 inverted", 1, 1, 4, 3);
        for (int i = 0; i < 3; i++) begin
            p = 2 + int'($urandom % 12);
            d = 1 + int'($urandom % (p - 1));
            run_case("R10 slow random", 0, int'($urandom % 2), p, d);
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule